// File: doc/BRIEF.md
# Core Task Sequencer with Late-Error Rollback

This block is the per-core control machine that runs one task at a time under soft-error protection. A scheduler hands it a task identifier and a start address. The block then loads the program counter and reports the start. It watches for the datapath's completion signal and for the error interrupt raised by the core's timing sensors. When an error arrives, the block enters exception handling. It reloads the program counter with the task's start address and restarts the task, and it reports each step.

The sensors flag an upset one or more cycles after it happens. For this reason a completed task is not declared finished at once. A safety window of `SAFE_CYC` cycles follows every busy-to-free move. An error inside that window rolls the just-completed task back. An error in the free state outside the window is discarded. The input data of a task must stay held until the task is finished cleanly, and `in_keep` tells the buffer owner when that is. Explicit sleep and wake inputs gate the core into and out of a clock-off state.

Top module: `core_task_ctrl`

## Requirements
- R1: After reset, `state_o` is FREE and `cmd_ready` is 1, with `rpt_valid`, `pc_load` and `in_keep` at 0. The state codes are OFF=0, FREE=1, BUSY=2 and EXC=3.
- R2: A command (`cmd_valid` while `cmd_ready`) takes effect in the next cycle: state BUSY, `pc_load` pulses with `pc_addr` equal to the command address, a report of type START (code 0) carries the command's task id, `in_keep` becomes 1 and `cmd_ready` becomes 0.
- R3: `cmd_ready` is 0 in BUSY, EXC and OFF, and during the safety window. A command presented then is not taken and produces no report and no program counter load.
- R4: If `task_done` is seen in BUSY without `err_irq`, the state becomes FREE and a safety window of `SAFE_CYC` cycles opens. In the cycle after the last window cycle, a report of type FINISH (code 1) is issued with the task id, and `cmd_ready` rises.
- R5: `err_irq` in BUSY, including in the same cycle as `task_done`, moves the state to EXC in the next cycle with a report of type ERROR (code 2) carrying the task id.
- R6: `err_irq` during the safety window moves the state to EXC with an ERROR report for the just-completed task. No FINISH report is issued for that run.
- R7: After the ERROR report comes one cycle with no report. The next cycle brings a report of type RESTART (code 3) with the same task id, a `pc_load` pulse with the stored start address, and state BUSY.
- R8: `err_irq` is ignored in FREE outside the safety window, in OFF and in EXC. It produces no report and no change of state.
- R9: `sleep_req` moves FREE to OFF only when FREE is idle (no window). A command in the same cycle takes priority. `sleep_req` in any other state or during the window is ignored. `wake_req` in OFF returns the block to FREE with `cmd_ready` 1.
- R10: `in_keep` is 1 from the cycle a command takes effect until the cycle of that task's FINISH report, and it stays 1 through every rollback.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Task command present |
| cmd_task | input | ID_W | Task identifier of the command |
| cmd_addr | input | PC_W | Start address of the commanded task |
| cmd_ready | output | 1 | Command can be accepted this cycle |
| task_done | input | 1 | Datapath finished the running task |
| err_irq | input | 1 | Soft-error interrupt from the sensors |
| sleep_req | input | 1 | Request to enter clock-off |
| wake_req | input | 1 | Request to leave clock-off |
| pc_load | output | 1 | Program counter load pulse |
| pc_addr | output | PC_W | Address to load into the program counter |
| rpt_valid | output | 1 | Report pulse |
| rpt_type | output | 2 | Report kind: START 0, FINISH 1, ERROR 2, RESTART 3 |
| rpt_task | output | ID_W | Task identifier of the report |
| in_keep | output | 1 | Task input data must be retained |
| state_o | output | 2 | Current state code |

## Verification
The bench sweeps the arrival cycle of the error interrupt across every cycle of the safety window and one cycle past it. A block whose window was one cycle short would declare the task finished and lose the rollback. A block whose window was one cycle long would roll back a task that had already been reported clean. The bench also checks an error and a completion in the same cycle, which would go wrong if completion won. It checks the exact gap between ERROR and RESTART, which would go wrong if the restart came too early or reported the wrong address. Commands, sleep requests and errors are also presented where they must be ignored, so a block that lost its task or left the wrong state on them shows up in the reports that follow.

// File: rtl/core_task_pkg.sv
package core_task_pkg;
  typedef enum logic [1:0] {
    ST_OFF  = 2'd0,
    ST_FREE = 2'd1,
    ST_BUSY = 2'd2,
    ST_EXC  = 2'd3
  } core_state_e;

  typedef enum logic [1:0] {
    RPT_START   = 2'd0,
    RPT_FINISH  = 2'd1,
    RPT_ERROR   = 2'd2,
    RPT_RESTART = 2'd3
  } report_e;
endpackage

// File: rtl/ctl_safe_window.sv
module ctl_safe_window #(
  parameter int unsigned SAFE_CYC = 1
) (
  input  logic clk,
  input  logic rst,
  input  logic arm,
  input  logic cancel,
  output logic active,
  output logic last
);
  localparam int unsigned CW = $clog2(SAFE_CYC + 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || cancel) begin
      cnt <= '0;
    end else if (arm) begin
      cnt <= CW'(SAFE_CYC);
    end else if (cnt != '0) begin
      cnt <= cnt - 1'b1;
    end
  end

  assign active = (cnt != '0);
  assign last   = (cnt == CW'(1));
endmodule

// File: rtl/ctl_task_slot.sv
module ctl_task_slot #(
  parameter int unsigned ID_W = 8,
  parameter int unsigned PC_W = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            load,
  input  logic [ID_W-1:0] id_in,
  input  logic [PC_W-1:0] addr_in,
  output logic [ID_W-1:0] id_q,
  output logic [PC_W-1:0] addr_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      id_q   <= '0;
      addr_q <= '0;
    end else if (load) begin
      id_q   <= id_in;
      addr_q <= addr_in;
    end
  end
endmodule

// File: rtl/core_task_ctrl.sv
module core_task_ctrl
  import core_task_pkg::*;
#(
  parameter int unsigned ID_W     = 8,
  parameter int unsigned PC_W     = 32,
  parameter int unsigned SAFE_CYC = 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            cmd_valid,
  input  logic [ID_W-1:0] cmd_task,
  input  logic [PC_W-1:0] cmd_addr,
  output logic            cmd_ready,
  input  logic            task_done,
  input  logic            err_irq,
  input  logic            sleep_req,
  input  logic            wake_req,
  output logic            pc_load,
  output logic [PC_W-1:0] pc_addr,
  output logic            rpt_valid,
  output logic [1:0]      rpt_type,
  output logic [ID_W-1:0] rpt_task,
  output logic            in_keep,
  output logic [1:0]      state_o
);
  core_state_e     st;
  logic            exc_wait;
  logic            win_active, win_last;
  logic            accept, arm_win, cancel_win;
  logic [ID_W-1:0] slot_id;
  logic [PC_W-1:0] slot_addr;

  assign accept     = (st == ST_FREE) && !win_active && cmd_valid;
  assign arm_win    = (st == ST_BUSY) && task_done && !err_irq;
  assign cancel_win = (st == ST_FREE) && win_active && err_irq;

  ctl_safe_window #(.SAFE_CYC(SAFE_CYC)) win_i (
    .clk(clk), .rst(rst), .arm(arm_win), .cancel(cancel_win),
    .active(win_active), .last(win_last)
  );

  ctl_task_slot #(.ID_W(ID_W), .PC_W(PC_W)) slot_i (
    .clk(clk), .rst(rst), .load(accept), .id_in(cmd_task), .addr_in(cmd_addr),
    .id_q(slot_id), .addr_q(slot_addr)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_FREE;
      exc_wait  <= 1'b0;
      cmd_ready <= 1'b1;
      pc_load   <= 1'b0;
      pc_addr   <= '0;
      rpt_valid <= 1'b0;
      rpt_type  <= RPT_START;
      rpt_task  <= '0;
      in_keep   <= 1'b0;
    end else begin
      pc_load   <= 1'b0;
      rpt_valid <= 1'b0;
      unique case (st)
        ST_OFF: begin
          if (wake_req) begin
            st        <= ST_FREE;
            cmd_ready <= 1'b1;
          end
        end
        ST_FREE: begin
          if (win_active) begin
            if (err_irq) begin
              st        <= ST_EXC;
              exc_wait  <= 1'b0;
              rpt_valid <= 1'b1;
              rpt_type  <= RPT_ERROR;
              rpt_task  <= slot_id;
            end else if (win_last) begin
              rpt_valid <= 1'b1;
              rpt_type  <= RPT_FINISH;
              rpt_task  <= slot_id;
              in_keep   <= 1'b0;
              cmd_ready <= 1'b1;
            end
          end else if (cmd_valid) begin
            st        <= ST_BUSY;
            pc_load   <= 1'b1;
            pc_addr   <= cmd_addr;
            rpt_valid <= 1'b1;
            rpt_type  <= RPT_START;
            rpt_task  <= cmd_task;
            in_keep   <= 1'b1;
            cmd_ready <= 1'b0;
          end else if (sleep_req) begin
            st        <= ST_OFF;
            cmd_ready <= 1'b0;
          end
        end
        ST_BUSY: begin
          if (err_irq) begin
            st        <= ST_EXC;
            exc_wait  <= 1'b0;
            rpt_valid <= 1'b1;
            rpt_type  <= RPT_ERROR;
            rpt_task  <= slot_id;
          end else if (task_done) begin
            st <= ST_FREE;
          end
        end
        ST_EXC: begin
          if (!exc_wait) begin
            exc_wait <= 1'b1;
          end else begin
            st        <= ST_BUSY;
            pc_load   <= 1'b1;
            pc_addr   <= slot_addr;
            rpt_valid <= 1'b1;
            rpt_type  <= RPT_RESTART;
            rpt_task  <= slot_id;
          end
        end
        default: st <= ST_FREE;
      endcase
    end
  end

  assign state_o = st;
endmodule

// File: rtl/core_task_ctrl_chk.sv
module core_task_ctrl_chk (
  input logic       clk,
  input logic       rst,
  input logic       cmd_ready,
  input logic       pc_load,
  input logic       rpt_valid,
  input logic [1:0] rpt_type,
  input logic       in_keep,
  input logic [1:0] state_o
);
  // R3: commands can be taken only in the free state
  a_r3_ready_only_free: assert property (@(posedge clk) disable iff (rst)
    cmd_ready |-> state_o == 2'd1);

  // R2, R7: a program counter load always comes with the busy state
  a_r7_load_in_busy: assert property (@(posedge clk) disable iff (rst)
    pc_load |-> state_o == 2'd2);

  // R5, R6: an error report is seen only in exception handling
  a_r5_error_in_exc: assert property (@(posedge clk) disable iff (rst)
    (rpt_valid && rpt_type == 2'd2) |-> state_o == 2'd3);

  // R7: a quiet cycle follows each error report
  a_r7_gap_after_error: assert property (@(posedge clk) disable iff (rst)
    (rpt_valid && rpt_type == 2'd2) |=> !rpt_valid);

  // R7: a restart report reloads the program counter
  a_r7_restart_loads: assert property (@(posedge clk) disable iff (rst)
    (rpt_valid && rpt_type == 2'd3) |-> pc_load);

  // R9: clock off is never reached directly from busy or exception
  a_r9_off_from_free: assert property (@(posedge clk) disable iff (rst)
    (state_o == 2'd2 || state_o == 2'd3) |=> state_o != 2'd0);

  // R10: input data is held while a task is running or recovering
  a_r10_keep_held: assert property (@(posedge clk) disable iff (rst)
    (state_o == 2'd2 || state_o == 2'd3) |-> in_keep);

  // R10: the finish report releases input data
  a_r10_finish_releases: assert property (@(posedge clk) disable iff (rst)
    (rpt_valid && rpt_type == 2'd1) |-> !in_keep);
endmodule

bind core_task_ctrl core_task_ctrl_chk chk_i (
  .clk(clk), .rst(rst), .cmd_ready(cmd_ready), .pc_load(pc_load),
  .rpt_valid(rpt_valid), .rpt_type(rpt_type), .in_keep(in_keep), .state_o(state_o)
);

// File: tb/core_task_ctrl_tb_top.sv
`timescale 1ns/1ps
module core_task_ctrl_tb_top;
  localparam int ID_W = 4;
  localparam int PC_W = 8;
  localparam int W    = 2;

  logic            clk = 1'b0;
  logic            rst;
  logic            cmd_valid, task_done, err_irq, sleep_req, wake_req;
  logic [ID_W-1:0] cmd_task;
  logic [PC_W-1:0] cmd_addr;
  logic            cmd_ready, pc_load, rpt_valid, in_keep;
  logic [PC_W-1:0] pc_addr;
  logic [1:0]      rpt_type, state_o;
  logic [ID_W-1:0] rpt_task;

  int total = 0;
  int bad   = 0;
  bit done_flag = 0;

  always #4 clk = ~clk;

  core_task_ctrl #(.ID_W(ID_W), .PC_W(PC_W), .SAFE_CYC(W)) dut_i (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_task(cmd_task),
    .cmd_addr(cmd_addr), .cmd_ready(cmd_ready), .task_done(task_done),
    .err_irq(err_irq), .sleep_req(sleep_req), .wake_req(wake_req),
    .pc_load(pc_load), .pc_addr(pc_addr), .rpt_valid(rpt_valid),
    .rpt_type(rpt_type), .rpt_task(rpt_task), .in_keep(in_keep), .state_o(state_o)
  );

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic ck(string req, string what, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic issue(int id, int addr);
    cmd_valid = 1'b1; cmd_task = ID_W'(id); cmd_addr = PC_W'(addr);
    tick();
    cmd_valid = 1'b0;
    ck("R2", "state", state_o, 2);
    ck("R2", "pc_load", pc_load, 1);
    ck("R2", "pc_addr", pc_addr, addr);
    ck("R2", "rpt_valid", rpt_valid, 1);
    ck("R2", "rpt_type", rpt_type, 0);
    ck("R2", "rpt_task", rpt_task, id);
    ck("R10", "in_keep", in_keep, 1);
    ck("R3", "cmd_ready busy", cmd_ready, 0);
  endtask

  task automatic finish_clean(int id);
    task_done = 1'b1;
    tick();
    task_done = 1'b0;
    ck("R4", "state after done", state_o, 1);
    ck("R3", "ready in window", cmd_ready, 0);
    ck("R4", "no early report", rpt_valid, 0);
    for (int i = 0; i < W - 1; i++) begin
      tick();
      ck("R4", "quiet window", rpt_valid, 0);
    end
    tick();
    ck("R4", "finish valid", rpt_valid, 1);
    ck("R4", "finish type", rpt_type, 1);
    ck("R4", "finish task", rpt_task, id);
    ck("R10", "keep released", in_keep, 0);
    ck("R4", "ready after finish", cmd_ready, 1);
  endtask

  task automatic expect_error(string req, int id);
    ck(req, "exc state", state_o, 3);
    ck(req, "error valid", rpt_valid, 1);
    ck(req, "error type", rpt_type, 2);
    ck(req, "error task", rpt_task, id);
    ck("R10", "keep in exc", in_keep, 1);
  endtask

  task automatic recover(int id, int addr);
    tick();
    ck("R7", "quiet exc", rpt_valid, 0);
    ck("R7", "no load yet", pc_load, 0);
    ck("R7", "still exc", state_o, 3);
    tick();
    ck("R7", "restart state", state_o, 2);
    ck("R7", "restart load", pc_load, 1);
    ck("R7", "restart addr", pc_addr, addr);
    ck("R7", "restart valid", rpt_valid, 1);
    ck("R7", "restart type", rpt_type, 3);
    ck("R7", "restart task", rpt_task, id);
  endtask

  initial begin
    int cyc = 0;
    while (!done_flag) begin
      @(posedge clk);
      cyc++;
      if (cyc > 50000) begin
        bad++;
        total++;
        $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end

  initial begin
    rst = 1'b1; cmd_valid = 0; task_done = 0; err_irq = 0; sleep_req = 0; wake_req = 0;
    cmd_task = '0; cmd_addr = '0;
    repeat (3) tick();
    rst = 1'b0;
    tick();
    ck("R1", "state", state_o, 1);
    ck("R1", "ready", cmd_ready, 1);
    ck("R1", "rpt_valid", rpt_valid, 0);
    ck("R1", "pc_load", pc_load, 0);
    ck("R1", "in_keep", in_keep, 0);

    // Sweep error arrival over each window cycle and one past it (R6, R8)
    for (int k = 0; k <= W; k++) begin
      int id = k + 1;
      int addr = k * 16 + 4;
      issue(id, addr);
      task_done = 1'b1;
      tick();
      task_done = 1'b0;
      for (int j = 0; j < W; j++) begin
        if (j == k) begin
          err_irq = 1'b1;
          tick();
          err_irq = 1'b0;
          expect_error("R6", id);
          break;
        end
        tick();
        if (j == W - 1) begin
          ck("R4", "finish type", rpt_type, 1);
          ck("R4", "finish valid", rpt_valid, 1);
        end else begin
          ck("R6", "no report yet", rpt_valid, 0);
        end
      end
      if (k < W) begin
        recover(id, addr);
        finish_clean(id);
      end else begin
        err_irq = 1'b1;
        tick();
        err_irq = 1'b0;
        ck("R8", "late err ignored state", state_o, 1);
        ck("R8", "late err no report", rpt_valid, 0);
        ck("R8", "ready kept", cmd_ready, 1);
      end
    end

    // R3: command while busy is not taken
    issue(9, 8'h30);
    cmd_valid = 1'b1; cmd_task = 4'd7; cmd_addr = 8'h77;
    tick();
    cmd_valid = 1'b0;
    ck("R3", "busy cmd no report", rpt_valid, 0);
    ck("R3", "busy cmd no load", pc_load, 0);
    // R5: error and done together; error wins
    err_irq = 1'b1; task_done = 1'b1;
    tick();
    err_irq = 1'b0; task_done = 1'b0;
    expect_error("R5", 9);
    // R3, R8: command and error during exception are ignored
    cmd_valid = 1'b1; cmd_task = 4'd6; cmd_addr = 8'h66; err_irq = 1'b1;
    ck("R3", "ready in exc", cmd_ready, 0);
    recover(9, 8'h30);
    cmd_valid = 1'b0; err_irq = 1'b0;
    // R3: command held during the window is not taken until ready
    task_done = 1'b1;
    tick();
    task_done = 1'b0;
    cmd_valid = 1'b1; cmd_task = 4'd11; cmd_addr = 8'hB0;
    for (int i = 0; i < W - 1; i++) begin
      tick();
      ck("R3", "window cmd no report", rpt_valid, 0);
    end
    tick();
    ck("R4", "finish despite cmd", rpt_type, 1);
    ck("R4", "finish task", rpt_task, 9);
    tick();
    cmd_valid = 1'b0;
    ck("R2", "cmd taken after ready", rpt_type, 0);
    ck("R2", "cmd task", rpt_task, 11);
    ck("R2", "cmd addr", pc_addr, 8'hB0);

    // R9: sleep ignored in busy and during the window
    sleep_req = 1'b1;
    tick();
    ck("R9", "sleep in busy", state_o, 2);
    task_done = 1'b1;
    tick();
    task_done = 1'b0;
    tick();
    ck("R9", "sleep in window", state_o, 1);
    sleep_req = 1'b0;
    tick();
    ck("R4", "finish after sleep", rpt_type, 1);
    // R9: command wins over sleep
    sleep_req = 1'b1;
    issue(12, 8'hC4);
    sleep_req = 1'b0;
    finish_clean(12);
    // R9: idle sleep, OFF ignores cmd and err, wake returns
    sleep_req = 1'b1;
    tick();
    sleep_req = 1'b0;
    ck("R9", "off state", state_o, 0);
    ck("R3", "ready off", cmd_ready, 0);
    cmd_valid = 1'b1; err_irq = 1'b1;
    tick();
    cmd_valid = 1'b0; err_irq = 1'b0;
    ck("R3", "off cmd ignored", state_o, 0);
    ck("R8", "off err no report", rpt_valid, 0);
    wake_req = 1'b1;
    tick();
    wake_req = 1'b0;
    ck("R9", "woken", state_o, 1);
    ck("R9", "ready after wake", cmd_ready, 1);
    issue(13, 8'hD0);
    finish_clean(13);

    done_flag = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule